// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap FIR filter that takes a whole block of three consecutive input samples on every clock and returns three filtered outputs on the same clock. Because of this, the sample rate is three times the clock rate. Each output lane has its own copy of the multiply-add tree.

The filter needs terms that cross from one block into the next. To form them, it keeps the two newest samples of the last accepted block in a small history register. The three coefficients are set at elaboration time. One valid strobe qualifies the whole input block.

Results are registered, so they appear one clock after their block is accepted. The output width is twice the sample width plus two bits, which is enough for every coefficient and sample combination. No result is saturated or rounded.

Top module: `par3_fir`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` and all three outputs are 0 after that edge, and the sample history is cleared to zero.
- R2: Lane 0 output equals A·x(3k) + B·x(3k−1) + C·x(3k−2). Here x(3k−1) and x(3k−2) are lanes 2 and 1 of the previously accepted block.
- R3: Lane 1 output equals A·x(3k+1) + B·x(3k) + C·x(3k−1). Here x(3k−1) is lane 2 of the previously accepted block.
- R4: Lane 2 output equals A·x(3k+2) + B·x(3k+1) + C·x(3k), using only the current block.
- R5: `out_valid` is high in the cycle after an edge where `in_valid` was high, and low in the cycle after an edge where it was low.
- R6: The history registers load only on accepted blocks. Samples presented with `in_valid` low have no effect on later results.
- R7: When `in_valid` is low at an edge, all three outputs keep their previous values.
- R8: Arithmetic is signed two's complement at full precision, with no saturation. Samples and coefficients are SW bits wide and results are 2·SW+2 bits wide.
- R9: The first block after reset is filtered as if all earlier samples were zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input block is valid this cycle |
| x0 | input | SW | Sample x(3k), signed |
| x1 | input | SW | Sample x(3k+1), signed |
| x2 | input | SW | Sample x(3k+2), signed |
| out_valid | output | 1 | Output block is valid |
| y0 | output | 2·SW+2 | Output y(3k), signed |
| y1 | output | 2·SW+2 | Output y(3k+1), signed |
| y2 | output | 2·SW+2 | Output y(3k+2), signed |

## Verification
The assertions assume the sample lanes are known, non-X values whenever `in_valid` is high. They also assume that the history comes only from blocks accepted since the last reset.

The bench drives every input away from the clock edge, on the falling edge. During idle cycles it deliberately puts unrelated values on the sample lanes, so that a history register that loads without a valid block is exposed. A second instance uses the most negative coefficients. It is fed both extreme sample values, so the widest products and sums are reached without leaving the signed range.

// File: rtl/par3_fir_pkg.sv
// Package: shared constants and width helpers for the three-lane block FIR.
// Assumes two's complement samples and coefficients of equal width.
package par3_fir_pkg;

    // Number of samples handled per clock.
    localparam int LANES = 3;

    // Number of taps; the window spans LANES + TAPS - 1 samples.
    localparam int TAPS  = 3;

    // Width of a full-precision result for a given sample width.
    function automatic int acc_width(input int sw);
        return 2 * sw + 2;
    endfunction

endpackage

// File: rtl/par3_fir_hist.sv
// Module: par3_fir_hist
// Holds lanes 1 and 2 of the last accepted block so that the next block
// can form its cross-block terms. Loads only when the block is valid.
// Assumes a synchronous active-low reset that clears the history to zero.
module par3_fir_hist #(
    parameter int SW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [SW-1:0] lane_mid,
    input  logic signed [SW-1:0] lane_new,
    output logic signed [SW-1:0] hist_mid,
    output logic signed [SW-1:0] hist_new
);

    // Capture the two newest samples of each accepted block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_mid <= '0;
            hist_new <= '0;
        end else if (load) begin
            hist_mid <= lane_mid;
            hist_new <= lane_new;
        end
    end

endmodule

// File: rtl/par3_fir_mac.sv
// Module: par3_fir_mac
// Combinational three-term multiply-add for one output lane:
// CA*s_cur + CB*s_d1 + CC*s_d2, computed at full precision.
// Assumes OW >= 2*SW+2, so that three signed products cannot overflow.
module par3_fir_mac #(
    parameter int SW     = 8,
    parameter int OW     = 18,
    parameter int COEF_A = 1,
    parameter int COEF_B = 0,
    parameter int COEF_C = 0
) (
    input  logic signed [SW-1:0] s_cur,
    input  logic signed [SW-1:0] s_d1,
    input  logic signed [SW-1:0] s_d2,
    output logic signed [OW-1:0] acc
);

    localparam int PW = 2 * SW;
    localparam logic signed [SW-1:0] CA = COEF_A[SW-1:0];
    localparam logic signed [SW-1:0] CB = COEF_B[SW-1:0];
    localparam logic signed [SW-1:0] CC = COEF_C[SW-1:0];

    logic signed [PW-1:0] prod_a;
    logic signed [PW-1:0] prod_b;
    logic signed [PW-1:0] prod_c;

    // Form the three products at double width.
    always_comb begin
        prod_a = PW'(s_cur) * PW'(CA);
        prod_b = PW'(s_d1)  * PW'(CB);
        prod_c = PW'(s_d2)  * PW'(CC);
    end

    // Sign-extend and sum; the first add and the second add form the tree.
    always_comb begin
        acc = OW'(prod_a) + OW'(prod_b) + OW'(prod_c);
    end

endmodule

// File: rtl/par3_fir_outreg.sv
// Module: par3_fir_outreg
// Result register for all lanes plus the output valid flag.
// Lanes load on a valid block and hold otherwise; valid follows the input
// strobe by one clock. Synchronous active-low reset clears everything.
module par3_fir_outreg #(
    parameter int OW    = 18,
    parameter int LANES = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [LANES-1:0][OW-1:0]   lane_d,
    output logic [LANES-1:0][OW-1:0]   lane_q,
    output logic                       valid_q
);

    // Register the lane results when a block is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else if (load) begin
            lane_q <= lane_d;
        end
    end

    // Delay the valid strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
        end
    end

endmodule

// File: rtl/par3_fir.sv
// Module: par3_fir (top)
// Three-lane block FIR: three samples in and three results out per clock.
// The sample window is {hist_mid, hist_new, x0, x1, x2}. Lane g uses window
// entries g+2, g+1 and g as its current, one-back and two-back samples.
// Assumes the coefficients fit in SW signed bits.
module par3_fir
    import par3_fir_pkg::*;
#(
    parameter int SW     = 8,
    parameter int OW     = acc_width(SW),
    parameter int COEF_A = 2,
    parameter int COEF_B = -3,
    parameter int COEF_C = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] x0,
    input  logic signed [SW-1:0] x1,
    input  logic signed [SW-1:0] x2,
    output logic                 out_valid,
    output logic signed [OW-1:0] y0,
    output logic signed [OW-1:0] y1,
    output logic signed [OW-1:0] y2
);

    localparam int WIN = LANES + TAPS - 1;

    logic signed [SW-1:0]       hist_mid;
    logic signed [SW-1:0]       hist_new;
    logic signed [SW-1:0]       win [WIN];
    logic [LANES-1:0][OW-1:0]   lane_sum;
    logic [LANES-1:0][OW-1:0]   lane_reg;

    // History of the previous block's last two samples.
    par3_fir_hist #(.SW(SW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (in_valid),
        .lane_mid (x1),
        .lane_new (x2),
        .hist_mid (hist_mid),
        .hist_new (hist_new)
    );

    // Assemble the sliding sample window, oldest first.
    always_comb begin
        win[0] = hist_mid;
        win[1] = hist_new;
        win[2] = x0;
        win[3] = x1;
        win[4] = x2;
    end

    // One replicated multiply-add tree per output lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [OW-1:0] acc;

        par3_fir_mac #(
            .SW     (SW),
            .OW     (OW),
            .COEF_A (COEF_A),
            .COEF_B (COEF_B),
            .COEF_C (COEF_C)
        ) u_mac (
            .s_cur (win[g+2]),
            .s_d1  (win[g+1]),
            .s_d2  (win[g]),
            .acc   (acc)
        );

        assign lane_sum[g] = acc;
    end

    // Output register stage.
    par3_fir_outreg #(.OW(OW), .LANES(LANES)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .lane_d  (lane_sum),
        .lane_q  (lane_reg),
        .valid_q (out_valid)
    );

    // Drive the signed output ports from the lane register.
    always_comb begin
        y0 = lane_reg[0];
        y1 = lane_reg[1];
        y2 = lane_reg[2];
    end

endmodule

// File: rtl/par3_fir_chk.sv
// Module: par3_fir_chk
// Property checker bound to par3_fir. It keeps its own port-level record
// of the last accepted block's lanes 1 and 2 to predict the results.
module par3_fir_chk #(
    parameter int SW     = 8,
    parameter int OW     = 18,
    parameter int COEF_A = 2,
    parameter int COEF_B = -3,
    parameter int COEF_C = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] x0,
    input  logic signed [SW-1:0] x1,
    input  logic signed [SW-1:0] x2,
    input  logic                 out_valid,
    input  logic signed [OW-1:0] y0,
    input  logic signed [OW-1:0] y1,
    input  logic signed [OW-1:0] y2
);

    localparam logic signed [SW-1:0] KA = COEF_A[SW-1:0];
    localparam logic signed [SW-1:0] KB = COEF_B[SW-1:0];
    localparam logic signed [SW-1:0] KC = COEF_C[SW-1:0];

    logic signed [SW-1:0] seen_mid;
    logic signed [SW-1:0] seen_new;
    logic signed [OW-1:0] pred0;
    logic signed [OW-1:0] pred1;
    logic signed [OW-1:0] pred2;

    function automatic logic signed [OW-1:0] tap3(
        input logic signed [SW-1:0] cur,
        input logic signed [SW-1:0] d1,
        input logic signed [SW-1:0] d2
    );
        return OW'(cur) * OW'(KA) + OW'(d1) * OW'(KB) + OW'(d2) * OW'(KC);
    endfunction

    // Port-level record of the previous accepted block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_mid <= '0;
            seen_new <= '0;
        end else if (in_valid) begin
            seen_mid <= x1;
            seen_new <= x2;
        end
    end

    // Predicted results for the block on the inputs now.
    always_comb begin
        pred0 = tap3(x0, seen_new, seen_mid);
        pred1 = tap3(x1, x0, seen_new);
        pred2 = tap3(x2, x1, x0);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && y0 == '0 && y1 == '0 && y2 == '0));

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R5
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    lane0_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> y0 == $past(pred0));

    // R3
    lane1_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> y1 == $past(pred1));

    // R4
    lane2_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> y2 == $past(pred2));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(y0) && $stable(y1) && $stable(y2)));

endmodule

bind par3_fir par3_fir_chk #(
    .SW     (SW),
    .OW     (OW),
    .COEF_A (COEF_A),
    .COEF_B (COEF_B),
    .COEF_C (COEF_C)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .x0        (x0),
    .x1        (x1),
    .x2        (x2),
    .out_valid (out_valid),
    .y0        (y0),
    .y1        (y1),
    .y2        (y2)
);

// File: tb/tb_par3_fir.sv
module tb_par3_fir;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int OW = 2 * SW + 2;
    localparam int NVEC = 4;

    // Each row: x0, x1, x2, expected y0, y1, y2 (A=2, B=-3, C=5, zero history).
    localparam int VEC [NVEC][6] = '{
        '{  1,  2,   3,  2,   1,   5},
        '{  4, -1,   0,  9,   1,  23},
        '{ -2,  5,  -6, -9,  16, -37},
        '{ 10,  0, -10, 63, -60,  30}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [SW-1:0] x0 = '0, x1 = '0, x2 = '0;
    logic                 out_valid;
    logic signed [OW-1:0] y0, y1, y2;

    logic                 w_valid = 1'b0;
    logic signed [SW-1:0] w0 = '0, w1 = '0, w2 = '0;
    logic                 w_out_valid;
    logic signed [OW-1:0] wy0, wy1, wy2;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    par3_fir #(.SW(SW), .COEF_A(2), .COEF_B(-3), .COEF_C(5)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x0(x0), .x1(x1), .x2(x2),
        .out_valid(out_valid), .y0(y0), .y1(y1), .y2(y2)
    );

    par3_fir #(.SW(SW), .COEF_A(-128), .COEF_B(-128), .COEF_C(-128)) dut_wide (
        .clk(clk), .rst_n(rst_n), .in_valid(w_valid),
        .x0(w0), .x1(w1), .x2(w2),
        .out_valid(w_out_valid), .y0(wy0), .y1(wy1), .y2(wy2)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input bit v, input int a, input int b, input int c);
        in_valid = v;
        x0 = SW'(a);
        x1 = SW'(b);
        x2 = SW'(c);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 y0", int'(y0), 0);
        check("R1 y1", int'(y1), 0);
        check("R1 y2", int'(y2), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5 R9: table of blocks starting from zero history
        for (int i = 0; i < NVEC; i++) begin
            put(1'b1, VEC[i][0], VEC[i][1], VEC[i][2]);
            check("R5 out_valid", int'(out_valid), 1);
            check("R2 y0", int'(y0), VEC[i][3]);
            check("R3 y1", int'(y1), VEC[i][4]);
            check("R4 y2", int'(y2), VEC[i][5]);
        end

        // R7 R5: idle cycles with unrelated sample values
        for (int i = 0; i < 2; i++) begin
            put(1'b0, 99, -77, 55);
            check("R5 idle out_valid", int'(out_valid), 0);
            check("R7 y0 hold", int'(y0), 63);
            check("R7 y1 hold", int'(y1), -60);
            check("R7 y2 hold", int'(y2), 30);
        end

        // R6: history still holds lanes 0 and -10 from the last valid block
        put(1'b1, 1, 1, 1);
        check("R6 y0", int'(y0), 32);
        check("R6 y1", int'(y1), -51);
        check("R6 y2", int'(y2), 4);

        // R1: reset in mid-run wins over a valid block
        rst_n = 1'b0;
        put(1'b1, 7, 7, 7);
        check("R1 mid out_valid", int'(out_valid), 0);
        check("R1 mid y0", int'(y0), 0);
        check("R1 mid y2", int'(y2), 0);
        rst_n = 1'b1;

        // R9: the first block after reset sees a zero history
        put(1'b1, 1, 2, 3);
        check("R9 y0", int'(y0), 2);
        check("R9 y1", int'(y1), 1);
        check("R9 y2", int'(y2), 5);
        put(1'b0, 0, 0, 0);

        // R8: extreme values on the wide-coefficient instance
        w_valid = 1'b1; w0 = -8'sd128; w1 = -8'sd128; w2 = -8'sd128;
        @(negedge clk);
        check("R8 wide y0", int'(wy0), 16384);
        check("R8 wide y1", int'(wy1), 32768);
        check("R8 wide y2", int'(wy2), 49152);
        w0 = 8'sd127; w1 = 8'sd127; w2 = 8'sd127;
        @(negedge clk);
        check("R8 wide y0 mix", int'(wy0), 16512);
        check("R8 wide y1 mix", int'(wy1), -16128);
        check("R8 wide y2 max", int'(wy2), -48768);
        w_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule